// File: doc/BRIEF.md
# Four-Way Event Fan-Out with Header Filtering and Prescaling

This block takes framed events from one upstream event queue and copies each of them into up to four output streams. Each stream is a small queue that shows its head word. A downstream consumer drains it one word per pop. Every stream has its own acceptance rule:

- take everything;
- take only events whose selected header tag bits equal a programmed pattern;
- take one event in every N by prescaling;
- or apply the filter and the prescale together, so that both must pass.

A typical setup uses one stream as the full-data path, one as a preselected monitoring path and one as a prescaled trigger-verification path.

The acceptance vector is decided once, when the header word is taken, and then applies to the whole event. A header is taken only when every stream that will accept the event has room for an event of maximum length. Otherwise the input is stalled. Because of this, no stream ever receives part of an event.

The header also carries an event number. The block compares it with its own running count of trigger accepts. A difference raises a sticky error flag and records the received number. The count then continues from the received number plus one. The fill level of every stream is reported continuously. Configuration is written per stream and is staged until the distributor sits between events.

Top module: `evt_fanout`

## Requirements
- R1: After reset, every stream is empty with level 0, `out_valid` is low, `evn_err` is low, and `in_ready` is high while no header is offered.
- R2: Every word of an event accepted by a stream appears in that stream unchanged, in input order, with its start flag (bit DW+1 of the stored word) and end flag (bit DW), and with no word from a rejected event.
- R3: Header word layout is: event number in bits [EW-1:0] and tag in bits [EW+HW-1:EW]. With the filter enabled, a stream accepts only when (tag XOR match) AND mask is zero. With the filter disabled, the filter always passes.
- R4: With prescale enabled at ratio N, the stream's counter advances only on headers that pass its filter. The counter accepts the event on which it reaches N-1 and then returns to 0. N equal to 0 or 1 accepts every passing event.
- R5: With filter and prescale both enabled, an event is accepted only when both pass.
- R6: The acceptance vector fixed at the header holds for every following word up to and including the end word, even if a configuration write happens inside the event.
- R7: While idle, a header is taken (`in_ready` high) only if every stream that would accept it holds at most DEPTH-MAX_WORDS words. Otherwise `in_ready` is low. Inside an event `in_ready` is high.
- R8: A header whose event number differs from the expected count sets `evn_err`, which stays set until reset, and loads the received number into `evn_err_num`. After every header the expected count becomes the received number plus one. The count starts at 0.
- R9: A configuration write is held pending and becomes active only in a cycle where the distributor is idle and takes no header. Activation clears that stream's prescale counter.
- R10: `out_level` of each stream equals the number of words it holds, updated on the clock after each push or pop.
- R11: A word offered while idle without the start flag is consumed and written to no stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word available |
| in_ready | output | 1 | Word taken on this edge when high with `in_valid` |
| in_data | input | DW | Upstream word |
| in_sop | input | 1 | Word is an event header |
| in_eop | input | 1 | Word ends the event |
| cfg_we | input | 1 | Stage one stream's configuration |
| cfg_stream | input | 2 | Stream addressed by the write |
| cfg_filt_en | input | 1 | Enable header tag filter |
| cfg_pre_en | input | 1 | Enable prescale |
| cfg_mask | input | HW | Tag bits that take part in the comparison |
| cfg_match | input | HW | Required tag pattern |
| cfg_ratio | input | PW | Prescale ratio N |
| out_valid | output | 4 | Stream holds at least one word |
| out_pop | input | 4 | Remove the head word of the stream |
| out_data | output | 4*DW | Head words, stream s in bits [s*DW +: DW] |
| out_sop | output | 4 | Head word is a header |
| out_eop | output | 4 | Head word ends an event |
| out_level | output | 4*LW | Stream fill levels, LW = clog2(DEPTH+1) |
| evn_err | output | 1 | Sticky event-number mismatch flag |
| evn_err_num | output | EW | Event number of the latest mismatching header |

## Verification
The bench keeps a behavioural reference that decides acceptance, tracks prescale counts and stages configuration. It compares every stream's head, level and validity, and the input handshake, on each clock. The corner cases it targets are:

- **Streams left without draining to force stalls.** A wrong room test would overflow a stream or stall for no reason.
- **Configuration writes landing inside events.** Re-deciding mid-event would truncate or splice events.
- **Prescale ratios of 0, 1 and higher combined with a filter.** A counter that advanced on filtered-out events would pick the wrong events.
- **Forced event-number jumps.** A non-resynchronising count would flag every later header.
- **Headerless junk words.** These would leak into the streams if they were not dropped.

// File: rtl/evt_fanout_pkg.sv
package evt_fanout_pkg;
   localparam int NSTREAM = 4;
   typedef enum logic {ST_IDLE = 1'b0, ST_BODY = 1'b1} dist_state_t;
endpackage

// File: rtl/evt_stream_fifo.sv
module evt_stream_fifo #(
   parameter int W     = 34,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic          rvalid,
   output logic [W-1:0]  rdata,
   output logic [LW-1:0] level
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("evt_stream_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [LW-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         if (push && !pop)      lvl_q <= lvl_q + 1'b1;
         else if (pop && !push) lvl_q <= lvl_q - 1'b1;
      end
   end

   assign rvalid = (lvl_q != '0);
   assign rdata  = mem[rp_q];
   assign level  = lvl_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (lvl_q != LW'(DEPTH))); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> rvalid); // R2
   AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (level == $past(level) + 1'b1)); // R10
endmodule

// File: rtl/evt_stream_sel.sv
module evt_stream_sel #(
   parameter int HW     = 8,
   parameter int PW     = 8,
   parameter bit PRE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_filt_en,
   input  logic          cfg_pre_en,
   input  logic [HW-1:0] cfg_mask,
   input  logic [HW-1:0] cfg_match,
   input  logic [PW-1:0] cfg_ratio,
   input  logic          boundary,
   input  logic          hdr_take,
   input  logic [HW-1:0] hdr_tag,
   output logic          accept
);
   logic          pend_q, s_fen_q, s_pen_q, fen_q, pen_q;
   logic [HW-1:0] s_mask_q, s_match_q, mask_q, match_q;
   logic [PW-1:0] s_ratio_q, ratio_q;
   logic          apply, filt_ok, pre_hit;

   assign apply   = pend_q && boundary;
   assign filt_ok = !fen_q || (((hdr_tag ^ match_q) & mask_q) == '0);
   assign accept  = filt_ok && (!pen_q || pre_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0; s_fen_q <= 1'b0; s_pen_q <= 1'b0;
         s_mask_q <= '0; s_match_q <= '0; s_ratio_q <= '0;
         fen_q <= 1'b0; pen_q <= 1'b0;
         mask_q <= '0; match_q <= '0; ratio_q <= '0;
      end else begin
         if (cfg_we) begin
            pend_q    <= 1'b1;
            s_fen_q   <= cfg_filt_en;
            s_pen_q   <= cfg_pre_en;
            s_mask_q  <= cfg_mask;
            s_match_q <= cfg_match;
            s_ratio_q <= cfg_ratio;
         end else if (apply) begin
            pend_q <= 1'b0;
         end
         if (apply) begin
            fen_q   <= s_fen_q;
            pen_q   <= s_pen_q && PRE_EN;
            mask_q  <= s_mask_q;
            match_q <= s_match_q;
            ratio_q <= s_ratio_q;
         end
      end
   end

   if (PRE_EN) begin : g_pre
      logic [PW-1:0] pcnt_q;
      assign pre_hit = ({1'b0, pcnt_q} + 1'b1) >= {1'b0, ratio_q};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           pcnt_q <= '0;
         else if (apply)                       pcnt_q <= '0;
         else if (hdr_take && pen_q && filt_ok) pcnt_q <= pre_hit ? '0 : pcnt_q + 1'b1;
      end
      AST_PCNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
         (ratio_q > PW'(1)) |-> (pcnt_q < ratio_q)); // R4
   end else begin : g_nopre
      assign pre_hit = 1'b1;
   end
endmodule

// File: rtl/evt_fanout.sv
module evt_fanout #(
   parameter int DW        = 32,
   parameter int EW        = 8,
   parameter int HW        = 8,
   parameter int PW        = 8,
   parameter int DEPTH     = 16,
   parameter int MAX_WORDS = 8,
   localparam int NS       = evt_fanout_pkg::NSTREAM,
   localparam int LW       = $clog2(DEPTH + 1),
   localparam int FW       = DW + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [DW-1:0]    in_data,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_stream,
   input  logic             cfg_filt_en,
   input  logic             cfg_pre_en,
   input  logic [HW-1:0]    cfg_mask,
   input  logic [HW-1:0]    cfg_match,
   input  logic [PW-1:0]    cfg_ratio,
   output logic [NS-1:0]    out_valid,
   input  logic [NS-1:0]    out_pop,
   output logic [NS*DW-1:0] out_data,
   output logic [NS-1:0]    out_sop,
   output logic [NS-1:0]    out_eop,
   output logic [NS*LW-1:0] out_level,
   output logic             evn_err,
   output logic [EW-1:0]    evn_err_num
);
   import evt_fanout_pkg::*;

   if (EW + HW > DW) begin : g_bad_hdr
      $error("evt_fanout: header fields exceed word width");
   end
   if (MAX_WORDS > DEPTH || MAX_WORDS < 1) begin : g_bad_max
      $error("evt_fanout: MAX_WORDS must lie in 1..DEPTH");
   end

   dist_state_t   state_q;
   logic [NS-1:0] acc_now, acc_q, room, push;
   logic [EW-1:0] exp_q, num_q;
   logic          err_q, idle, room_ok, take, hdr_take, boundary;
   logic [HW-1:0] hdr_tag;
   logic [EW-1:0] hdr_evn;

   assign idle     = (state_q == ST_IDLE);
   assign hdr_tag  = in_data[EW +: HW];
   assign hdr_evn  = in_data[EW-1:0];
   assign room_ok  = &(~acc_now | room);
   assign in_ready = idle ? (!in_sop || room_ok) : 1'b1;
   assign take     = in_valid && in_ready;
   assign hdr_take = take && idle && in_sop;
   assign boundary = idle && !hdr_take;

   for (genvar s = 0; s < NS; s++) begin : g_stream
      logic [LW-1:0] lvl;
      logic [FW-1:0] head;

      evt_stream_sel #(.HW(HW), .PW(PW), .PRE_EN(1'b1)) u_sel (
         .clk(clk), .rst_n(rst_n),
         .cfg_we(cfg_we && (cfg_stream == 2'(s))),
         .cfg_filt_en(cfg_filt_en), .cfg_pre_en(cfg_pre_en),
         .cfg_mask(cfg_mask), .cfg_match(cfg_match), .cfg_ratio(cfg_ratio),
         .boundary(boundary), .hdr_take(hdr_take), .hdr_tag(hdr_tag),
         .accept(acc_now[s])
      );

      assign room[s] = (lvl <= LW'(DEPTH - MAX_WORDS));
      assign push[s] = hdr_take ? acc_now[s] : (take && !idle && acc_q[s]);

      evt_stream_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
         .clk(clk), .rst_n(rst_n),
         .push(push[s]), .wdata({in_sop, in_eop, in_data}),
         .pop(out_pop[s]), .rvalid(out_valid[s]), .rdata(head), .level(lvl)
      );

      assign out_data[s*DW +: DW]  = head[DW-1:0];
      assign out_eop[s]            = head[DW];
      assign out_sop[s]            = head[DW+1];
      assign out_level[s*LW +: LW] = lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         acc_q   <= '0;
      end else if (hdr_take && !in_eop) begin
         state_q <= ST_BODY;
         acc_q   <= acc_now;
      end else if (!idle && take && in_eop) begin
         state_q <= ST_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q <= '0;
         err_q <= 1'b0;
         num_q <= '0;
      end else if (hdr_take) begin
         exp_q <= hdr_evn + 1'b1;
         if (hdr_evn != exp_q) begin
            err_q <= 1'b1;
            num_q <= hdr_evn;
         end
      end
   end

   assign evn_err     = err_q;
   assign evn_err_num = num_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(evn_err) |-> evn_err); // R8
   AST_HOLD_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && $past(state_q == ST_BODY)) |-> $stable(acc_q)); // R6
   AST_BODY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> in_ready); // R7
endmodule

// File: tb/sim_evt_fanout.sv
`timescale 1ns/1ps
module sim_evt_fanout;
   localparam int DW = 32, EW = 8, HW = 8, PW = 8, DEPTH = 16, MAXW = 8;
   localparam int NS = 4;
   localparam int LW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_ready;
   logic [DW-1:0] in_data = '0;
   logic cfg_we = 1'b0, cfg_filt_en = 1'b0, cfg_pre_en = 1'b0;
   logic [1:0] cfg_stream = '0;
   logic [HW-1:0] cfg_mask = '0, cfg_match = '0;
   logic [PW-1:0] cfg_ratio = '0;
   logic [NS-1:0] out_valid, out_sop, out_eop;
   logic [NS-1:0] out_pop = '0;
   logic [NS*DW-1:0] out_data;
   logic [NS*LW-1:0] out_level;
   logic evn_err;
   logic [EW-1:0] evn_err_num;

   always #2.5 clk = ~clk;

   evt_fanout u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
      .cfg_we(cfg_we), .cfg_stream(cfg_stream), .cfg_filt_en(cfg_filt_en),
      .cfg_pre_en(cfg_pre_en), .cfg_mask(cfg_mask), .cfg_match(cfg_match),
      .cfg_ratio(cfg_ratio), .out_valid(out_valid), .out_pop(out_pop),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
      .out_level(out_level), .evn_err(evn_err), .evn_err_num(evn_err_num)
   );

   int total = 0, bad = 0;
   bit done = 1'b0;
   string ptag = "R2";
   int vprob = 80, pprob = 100, cfg_rate = 0;

   // reference state
   logic [DW+1:0] src[$];
   logic [DW+1:0] mq[NS][$];
   bit m_fen[NS], m_pen[NS], m_pend[NS], s_fen[NS], s_pen[NS];
   int m_mask[NS], m_match[NS], m_ratio[NS], s_mask[NS], s_match[NS], s_ratio[NS];
   int m_pcnt[NS];
   bit m_body = 1'b0, m_acc[NS];
   logic [EW-1:0] m_exp = '0, m_errnum = '0;
   bit m_err = 1'b0;
   int gen_evn = 0;

   // directed configuration request
   bit rq = 1'b0, rq_fen, rq_pen;
   int rq_s, rq_mask, rq_match, rq_ratio;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic bit m_filt(int s, logic [HW-1:0] tag);
      return !m_fen[s] || (((int'(tag) ^ m_match[s]) & m_mask[s]) == 0);
   endfunction
   function automatic bit m_prehit(int s);
      return (m_pcnt[s] + 1) >= m_ratio[s];
   endfunction
   function automatic bit m_accept(int s, logic [HW-1:0] tag);
      return m_filt(s, tag) && (!m_pen[s] || m_prehit(s));
   endfunction

   task automatic gen_ev(input int len, input bit bad_evn);
      logic [EW-1:0] evn;
      logic [HW-1:0] tag;
      evn = bad_evn ? EW'(gen_evn + 3) : EW'(gen_evn);
      gen_evn = int'(evn) + 1;
      tag = HW'($urandom);
      src.push_back({1'b1, len == 1, 16'($urandom), tag, evn});
      for (int i = 1; i < len; i++) src.push_back({1'b0, i == len - 1, 32'($urandom)});
   endtask

   task automatic step();
      bit acc[NS];
      bit exp_ready, take, hdr, was_body;
      logic [HW-1:0] tag;
      logic [DW+1:0] w, got;
      @(negedge clk);
      if (src.size() > 0 && $urandom_range(99) < vprob) begin
         in_valid = 1'b1;
         {in_sop, in_eop, in_data} = src[0];
      end else begin
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
      end
      for (int s = 0; s < NS; s++) out_pop[s] = out_valid[s] && ($urandom_range(99) < pprob);
      if (rq) begin
         cfg_we = 1'b1; cfg_stream = 2'(rq_s); cfg_filt_en = rq_fen; cfg_pre_en = rq_pen;
         cfg_mask = HW'(rq_mask); cfg_match = HW'(rq_match); cfg_ratio = PW'(rq_ratio);
         rq = 1'b0;
      end else if ($urandom_range(99) < cfg_rate) begin
         cfg_we = 1'b1; cfg_stream = 2'($urandom); cfg_filt_en = 1'($urandom);
         cfg_pre_en = 1'($urandom); cfg_mask = HW'($urandom) & 8'h03;
         cfg_match = HW'($urandom); cfg_ratio = PW'($urandom_range(3));
      end else cfg_we = 1'b0;
      #1;
      tag = in_data[EW +: HW];
      for (int s = 0; s < NS; s++) acc[s] = m_accept(s, tag);
      exp_ready = 1'b1;
      if (!m_body && in_sop)
         for (int s = 0; s < NS; s++)
            if (acc[s] && mq[s].size() > DEPTH - MAXW) exp_ready = 1'b0;
      chk(in_ready === exp_ready, "R7 ready", 64'(in_ready), 64'(exp_ready));
      for (int s = 0; s < NS; s++) begin
         chk(out_valid[s] === (mq[s].size() != 0), "R2 valid", 64'(out_valid[s]), 64'(mq[s].size() != 0));
         chk(out_level[s*LW +: LW] == LW'(mq[s].size()), "R10 level", 64'(out_level[s*LW +: LW]), 64'(mq[s].size()));
         if (mq[s].size() != 0) begin
            got = {out_sop[s], out_eop[s], out_data[s*DW +: DW]};
            chk(got === mq[s][0], {"R2 word ", ptag}, 64'(got), 64'(mq[s][0]));
         end
      end
      chk(evn_err === m_err, "R8 flag", 64'(evn_err), 64'(m_err));
      if (m_err) chk(evn_err_num === m_errnum, "R8 number", 64'(evn_err_num), 64'(m_errnum));
      // reference update for the coming edge
      was_body = m_body;
      take = in_valid && exp_ready;
      hdr = take && !m_body && in_sop;
      w = {in_sop, in_eop, in_data};
      for (int s = 0; s < NS; s++) if (out_pop[s] && mq[s].size() != 0) void'(mq[s].pop_front());
      if (hdr) begin
         for (int s = 0; s < NS; s++) begin
            if (acc[s]) mq[s].push_back(w);
            if (m_pen[s] && m_filt(s, tag)) m_pcnt[s] = m_prehit(s) ? 0 : m_pcnt[s] + 1;
         end
         if (in_data[EW-1:0] != m_exp) begin m_err = 1'b1; m_errnum = in_data[EW-1:0]; end
         m_exp = in_data[EW-1:0] + 1'b1;
         if (!in_eop) begin m_body = 1'b1; m_acc = acc; end
      end else if (take && m_body) begin
         for (int s = 0; s < NS; s++) if (m_acc[s]) mq[s].push_back(w);
         if (in_eop) m_body = 1'b0;
      end
      for (int s = 0; s < NS; s++)
         if (m_pend[s] && !was_body && !hdr) begin
            m_fen[s] = s_fen[s]; m_pen[s] = s_pen[s]; m_mask[s] = s_mask[s];
            m_match[s] = s_match[s]; m_ratio[s] = s_ratio[s]; m_pcnt[s] = 0; m_pend[s] = 1'b0;
         end
      if (cfg_we) begin
         s_fen[cfg_stream] = cfg_filt_en; s_pen[cfg_stream] = cfg_pre_en;
         s_mask[cfg_stream] = int'(cfg_mask); s_match[cfg_stream] = int'(cfg_match);
         s_ratio[cfg_stream] = int'(cfg_ratio); m_pend[cfg_stream] = 1'b1;
      end
      if (take) void'(src.pop_front());
   endtask

   task automatic setcfg(input int s, input bit fen, input bit pen, input int mask, input int match, input int ratio);
      rq = 1'b1; rq_s = s; rq_fen = fen; rq_pen = pen; rq_mask = mask; rq_match = match; rq_ratio = ratio;
      step();
   endtask

   task automatic drain();
      int guard = 0;
      bit busy = 1'b1;
      while (busy && guard < 6000) begin
         step();
         guard++;
         busy = (src.size() != 0);
         for (int s = 0; s < NS; s++) if (mq[s].size() != 0) busy = 1'b1;
      end
   endtask

   initial begin
      for (int s = 0; s < NS; s++) begin
         m_fen[s] = 0; m_pen[s] = 0; m_pend[s] = 0; m_mask[s] = 0; m_match[s] = 0;
         m_ratio[s] = 0; m_pcnt[s] = 0; m_acc[s] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(out_valid === 4'b0, "R1 valid", 64'(out_valid), 0);
      chk(out_level === '0, "R1 level", 64'(out_level), 0);
      chk(evn_err === 1'b0, "R1 err", 64'(evn_err), 0);
      chk(in_ready === 1'b1, "R1 ready", 64'(in_ready), 1);

      ptag = "R2";
      for (int i = 0; i < 20; i++) gen_ev($urandom_range(1, MAXW), 1'b0);
      drain();

      // R3 filter, R4 prescale, R5 both, R9 staged apply
      ptag = "R3 R4 R5 R9";
      setcfg(1, 1'b1, 1'b0, 8'h03, 8'h01, 0);
      setcfg(2, 1'b0, 1'b1, 0, 0, 3);
      setcfg(3, 1'b1, 1'b1, 8'h01, 8'h01, 2);
      pprob = 70;
      for (int i = 0; i < 60; i++) gen_ev($urandom_range(1, MAXW), 1'b0);
      drain();

      // R7 stall with no draining
      ptag = "R7";
      pprob = 0; vprob = 100;
      for (int i = 0; i < 12; i++) gen_ev(MAXW, 1'b0);
      repeat (80) step();
      pprob = 100;
      drain();

      // R8 event-number jumps
      ptag = "R8";
      vprob = 80;
      for (int i = 0; i < 20; i++) gen_ev($urandom_range(1, 4), (i % 5) == 2);
      drain();
      chk(evn_err === 1'b1, "R8 sticky after jumps", 64'(evn_err), 1);

      // R6 mid-event writes, R9 staging, R11 junk words, ratios 0..3
      ptag = "R6 R9 R11";
      cfg_rate = 12; pprob = 60;
      for (int i = 0; i < 80; i++) begin
         if ($urandom_range(3) == 0) src.push_back({1'b0, 1'($urandom), 32'($urandom)});
         gen_ev($urandom_range(1, MAXW), 1'b0);
      end
      drain();
      cfg_rate = 0;
      drain();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule